// File: doc/BRIEF.md
# Three-wire wiper position controller

This block is the digital control section of a 32-tap digitally controlled potentiometer. It samples three asynchronous control lines on the system clock: an active-low select, a direction level and an increment strobe. It keeps a saturating wiper position counter and decodes that position into a one-hot tap-select vector, which drives the switch network of an analog resistor array.

A persistent register models the nonvolatile memory. Deselecting the block while the increment line is high writes the live position into that register, which takes a fixed number of clock cycles. After the write the block enters standby. Deselecting while the increment line is low leaves the register untouched. The register has its own clear input, so it keeps its contents across a power cycle on `pwr_rst_n`. Each time the block leaves reset it reloads the wiper from the register.

Top module: `tapwiper_ctrl`

## Requirements
- R1: One clock cycle after `pwr_rst_n` is released, `wiper_pos` holds the last value written to the persistent register. The register reads 0 after `nv_clr_n` has been asserted.
- R2: The position saturates at both ends. A step up at 31 leaves 31, and a step down at 0 leaves 0.
- R3: The position changes only on a high-to-low transition of `inc_strobe` while the block is selected. Rising edges of `inc_strobe` do not move the wiper, and neither do falling edges while `cs_n` is high.
- R4: If `up_dn` is 1 at an increment falling edge, that step adds one. If `up_dn` is 0, the step subtracts one.
- R5: A rise of `cs_n` while `inc_strobe` is high starts a store of the position. `store_busy` is 1 for exactly STORE_CYCLES consecutive cycles, starting 3 clock edges after the `cs_n` change.
- R6: A rise of `cs_n` while `inc_strobe` is low stores nothing and never raises `store_busy`. The wiper keeps its live value. A following power cycle recalls the older stored value.
- R7: When a store completes, `standby` goes to 1. It stays 1, including through a rise of `cs_n`, until `cs_n` falls again.
- R8: While `store_busy` is 1, the block ignores increment falling edges and falls of `cs_n`. The position does not change, and the block still enters standby afterwards.
- R9: `tap_sel` always has exactly one bit set, and that bit's index equals `wiper_pos`.
- R10: Every input passes through a two-flop synchronizer. A step shows up on `wiper_pos` on the 3rd rising clock edge after the `inc_strobe` fall, and not on the 2nd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pwr_rst_n | input | 1 | Active-low asynchronous reset; simulates a power cycle |
| nv_clr_n | input | 1 | Active-low clear of the persistent position register (first power-up only) |
| cs_n | input | 1 | Active-low select, asynchronous |
| up_dn | input | 1 | Step direction: 1 up, 0 down |
| inc_strobe | input | 1 | Increment strobe; steps on its falling edge |
| tap_sel | output | TAPS | One-hot tap select |
| wiper_pos | output | log2(TAPS) | Live wiper position |
| store_busy | output | 1 | High while a store is in progress |
| standby | output | 1 | High in the post-store standby state |

## Verification
Every input crosses two synchronizer flops and one edge-detect flop, so a wiper step becomes visible 3 rising edges after the strobe fall. `store_busy` rises 3 edges after the `cs_n` rise and stays high for STORE_CYCLES cycles, and `standby` follows in the next cycle. A recall is visible one edge after reset is released. The bench changes inputs and samples outputs only on falling clock edges. For the latency checks it samples after exactly 2 and after exactly 3 rising edges. For all other checks it waits at least 4 edges after a change, and it counts the busy cycles one by one. The register's contents are read back through a power cycle and the recalled position.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_RECALL,
    ST_DESEL,
    ST_SEL,
    ST_BUSY,
    ST_STANDBY
  } tw_state_e;

  // Saturating single step, on a wide type; callers narrow the result.
  function automatic logic [7:0] tw_sat_next(input logic [7:0] cur,
                                             input logic       up,
                                             input logic [7:0] top);
    if (up) return (cur >= top) ? top : cur + 8'd1;
    else    return (cur == 8'd0) ? 8'd0 : cur - 8'd1;
  endfunction

endpackage

// File: rtl/tw_sync.sv
// Multi-flop synchronizer with one extra stage kept for edge detection.
module tw_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [W-1:0] stg [STAGES+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i <= STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q      = stg[STAGES-1];
  assign q_prev = stg[STAGES];

endmodule

// File: rtl/tw_ctrl.sv
// Select / store sequencer.
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int STORE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_s,
  input  logic cs_p,
  input  logic inc_s,
  input  logic inc_p,
  output logic recall,
  output logic step_en,
  output logic nv_we,
  output logic busy,
  output logic standby
);

  localparam int BCNT_W = (STORE_CYCLES > 1) ? $clog2(STORE_CYCLES) : 1;
  localparam logic [BCNT_W-1:0] BCNT_LOAD = BCNT_W'(STORE_CYCLES - 1);

  tw_state_e         state, nxt;
  logic [BCNT_W-1:0] bcnt;

  // named internal events
  logic cs_fall_evt, cs_rise_evt, inc_fall_evt, bcnt_zero;
  assign cs_fall_evt  = cs_p & ~cs_s;
  assign cs_rise_evt  = ~cs_p & cs_s;
  assign inc_fall_evt = inc_p & ~inc_s;
  assign bcnt_zero    = (bcnt == '0);

  always_comb begin
    nxt = state;
    case (state)
      ST_RECALL:  nxt = ST_DESEL;
      ST_DESEL:   if (cs_fall_evt) nxt = ST_SEL;
      ST_SEL:     if (cs_rise_evt) nxt = inc_s ? ST_BUSY : ST_DESEL;
      ST_BUSY:    if (bcnt_zero) nxt = ST_STANDBY;
      ST_STANDBY: if (cs_fall_evt) nxt = ST_SEL;
      default:    nxt = ST_DESEL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RECALL;
      bcnt  <= '0;
    end else begin
      state <= nxt;
      if (state == ST_SEL && nxt == ST_BUSY) bcnt <= BCNT_LOAD;
      else if (state == ST_BUSY && !bcnt_zero) bcnt <= bcnt - 1'b1;
    end
  end

  assign recall  = (state == ST_RECALL);
  assign step_en = (state == ST_SEL) && inc_fall_evt && !cs_rise_evt;
  assign nv_we   = (state == ST_BUSY) && bcnt_zero;
  assign busy    = (state == ST_BUSY);
  assign standby = (state == ST_STANDBY);

  assert_store_to_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nv_we |=> (standby && !busy));

  assert_standby_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !cs_fall_evt) |=> standby);

  assert_no_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SEL) && cs_rise_evt && !inc_s) |=> (!busy && !standby));

  assert_busy_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !nv_we) |=> busy);

  assert_store_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_SEL) && cs_rise_evt && inc_s) |=> busy);

  assert_no_step_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !step_en);

endmodule

// File: rtl/tw_counter.sv
// Saturating wiper position counter with recall load.
module tw_counter
  import tw_pkg::*;
#(
  parameter int TAPS  = 32,
  parameter int POS_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [POS_W-1:0] load_val,
  input  logic             step_en,
  input  logic             up,
  output logic [POS_W-1:0] pos
);

  localparam logic [POS_W-1:0] MAXP = POS_W'(TAPS - 1);

  logic [POS_W-1:0] step_val;
  assign step_val = POS_W'(tw_sat_next(8'(pos), up, 8'(TAPS - 1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos <= '0;
    else if (load)    pos <= load_val;
    else if (step_en) pos <= step_val;
  end

  assert_recall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (pos == $past(load_val)));

  assert_sat_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && up && pos == MAXP && !load) |=> (pos == MAXP));

  assert_sat_bottom_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !up && pos == '0 && !load) |=> (pos == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load) |=> $stable(pos));

  assert_up_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && up && pos != MAXP && !load) |=> (pos == $past(pos) + POS_W'(1)));

  assert_down_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !up && pos != '0 && !load) |=> (pos == $past(pos) - POS_W'(1)));

endmodule

// File: rtl/tw_decoder.sv
// Position to one-hot tap select.
module tw_decoder #(
  parameter int TAPS  = 32,
  parameter int POS_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap_sel
);

  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    assign tap_sel[t] = (pos == POS_W'(t));
  end

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(tap_sel) == 1) && tap_sel[pos]);

endmodule

// File: rtl/tw_nvcell.sv
// Persistent position register; cleared only by its own reset.
module tw_nvcell #(
  parameter int POS_W = 5
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             we,
  input  logic [POS_W-1:0] d,
  output logic [POS_W-1:0] q
);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)  q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/tapwiper_ctrl.sv
module tapwiper_ctrl #(
  parameter int TAPS         = 32,
  parameter int STORE_CYCLES = 8,
  parameter int SYNC_STAGES  = 2,
  localparam int POS_W       = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             pwr_rst_n,
  input  logic             nv_clr_n,
  input  logic             cs_n,
  input  logic             up_dn,
  input  logic             inc_strobe,
  output logic [TAPS-1:0]  tap_sel,
  output logic [POS_W-1:0] wiper_pos,
  output logic             store_busy,
  output logic             standby
);

  // synchronized bit order: {cs_n, inc_strobe, up_dn}
  logic [2:0] sync_q, sync_p;
  logic       recall, step_en, nv_we;
  logic [POS_W-1:0] nv_q;

  tw_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk    (clk),
    .rst_n  (pwr_rst_n),
    .d      ({cs_n, inc_strobe, up_dn}),
    .q      (sync_q),
    .q_prev (sync_p)
  );

  tw_ctrl #(.STORE_CYCLES(STORE_CYCLES)) u_ctrl (
    .clk     (clk),
    .rst_n   (pwr_rst_n),
    .cs_s    (sync_q[2]),
    .cs_p    (sync_p[2]),
    .inc_s   (sync_q[1]),
    .inc_p   (sync_p[1]),
    .recall  (recall),
    .step_en (step_en),
    .nv_we   (nv_we),
    .busy    (store_busy),
    .standby (standby)
  );

  tw_counter #(.TAPS(TAPS), .POS_W(POS_W)) u_cnt (
    .clk      (clk),
    .rst_n    (pwr_rst_n),
    .load     (recall),
    .load_val (nv_q),
    .step_en  (step_en),
    .up       (sync_q[0]),
    .pos      (wiper_pos)
  );

  tw_decoder #(.TAPS(TAPS), .POS_W(POS_W)) u_dec (
    .clk     (clk),
    .rst_n   (pwr_rst_n),
    .pos     (wiper_pos),
    .tap_sel (tap_sel)
  );

  tw_nvcell #(.POS_W(POS_W)) u_nv (
    .clk   (clk),
    .clr_n (nv_clr_n),
    .we    (nv_we),
    .d     (wiper_pos),
    .q     (nv_q)
  );

  assert_store_data_R5: assert property (@(posedge clk) disable iff (!pwr_rst_n || !nv_clr_n)
    nv_we |=> (nv_q == $past(wiper_pos)));

  assert_nv_quiet_R6: assert property (@(posedge clk) disable iff (!pwr_rst_n || !nv_clr_n)
    !nv_we |=> $stable(nv_q));

endmodule

// File: tb/tapwiper_ctrl_tb_top.sv
module tapwiper_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TAPS       = 32;
  localparam int SC         = 8;

  logic        clk = 1'b0;
  logic        pwr_rst_n, nv_clr_n, cs_n, up_dn, inc_strobe;
  logic [31:0] tap_sel;
  logic [4:0]  wiper_pos;
  logic        store_busy, standby;

  int total = 0;
  int bad   = 0;
  int exp_pos = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tapwiper_ctrl #(.TAPS(TAPS), .STORE_CYCLES(SC)) dut_i (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .nv_clr_n(nv_clr_n),
    .cs_n(cs_n), .up_dn(up_dn), .inc_strobe(inc_strobe),
    .tap_sel(tap_sel), .wiper_pos(wiper_pos),
    .store_busy(store_busy), .standby(standby)
  );

  function automatic int model_step(int p, bit up);
    if (up) return (p + 1 > TAPS - 1) ? TAPS - 1 : p + 1;
    return (p - 1 < 0) ? 0 : p - 1;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_pos(string tag);
    check(tag, wiper_pos, exp_pos);
    check({tag, " R9 tap"}, tap_sel, longint'(1) << exp_pos);
  endtask

  task automatic inc_fall(bit selected);
    inc_strobe = 1'b0;
    tick(4);
    if (selected) exp_pos = model_step(exp_pos, up_dn);
  endtask

  task automatic pulse(bit selected);
    inc_fall(selected);
    inc_strobe = 1'b1;
    tick(4);
  endtask

  task automatic power_cycle();
    pwr_rst_n = 1'b0;
    tick(3);
    pwr_rst_n = 1'b1;
    tick(1);
  endtask

  task automatic t_reset();
    nv_clr_n = 1'b0; pwr_rst_n = 1'b0;
    cs_n = 1'b1; inc_strobe = 1'b1; up_dn = 1'b0;
    tick(3);
    nv_clr_n = 1'b1; pwr_rst_n = 1'b1;
    tick(1);
    exp_pos = 0;
    check_pos("R1 recall after clear");
    check("R5 busy at reset", store_busy, 0);
    check("R7 standby at reset", standby, 0);
  endtask

  task automatic t_latency();
    cs_n = 1'b0; tick(4);
    up_dn = 1'b1; tick(4);
    inc_strobe = 1'b0;
    tick(2);
    check("R10 no step after 2 edges", wiper_pos, 0);
    tick(1);
    check("R10 step after 3 edges R4", wiper_pos, 1);
    exp_pos = 1;
    tick(2);
    inc_strobe = 1'b1; tick(4);
    check_pos("R3 rising strobe no step");
  endtask

  task automatic t_up_down();
    for (int i = 0; i < 4; i++) begin
      pulse(1);
      check_pos("R4 up step");
    end
    up_dn = 1'b0; tick(4);
    pulse(1); pulse(1);
    check_pos("R4 down steps");
  endtask

  task automatic t_store();
    int n;
    n = 0;
    cs_n = 1'b1;
    for (int i = 0; i < SC + 10; i++) begin
      tick(1);
      if (store_busy) n++;
    end
    check("R5 busy length", n, SC);
    check("R7 standby after store", standby, 1);
    cs_n = 1'b0; tick(4);
    check("R7 standby left on select", standby, 0);
  endtask

  task automatic t_desel_nostore(int stored);
    up_dn = 1'b1; tick(4);
    pulse(1); pulse(1); pulse(1);
    inc_fall(1);
    cs_n = 1'b1; tick(4);
    check("R6 no busy", store_busy, 0);
    check("R6 no standby", standby, 0);
    check_pos("R6 wiper kept");
    inc_strobe = 1'b1; tick(4);
    pulse(0); pulse(0); pulse(0);
    check_pos("R3 deselected strobes ignored");
    power_cycle();
    exp_pos = stored;
    check_pos("R6 R1 older value recalled");
  endtask

  task automatic t_busy_ignore();
    cs_n = 1'b0; tick(4);
    up_dn = 1'b1; tick(4);
    pulse(1);
    cs_n = 1'b1;
    tick(3);
    check("R5 busy starts after 3 edges", store_busy, 1);
    inc_strobe = 1'b0; cs_n = 1'b0;
    tick(4);
    inc_strobe = 1'b1;
    tick(SC + 6);
    check("R8 busy done", store_busy, 0);
    check("R8 standby despite reselect", standby, 1);
    check_pos("R8 strobe during busy ignored");
    cs_n = 1'b1; tick(4);
    check("R7 standby through cs rise", standby, 1);
    cs_n = 1'b0; tick(4);
    check("R7 standby exit", standby, 0);
    cs_n = 1'b1; inc_strobe = 1'b0; tick(4);
    inc_strobe = 1'b1;
    power_cycle();
    check_pos("R1 recall stored value");
  endtask

  task automatic t_saturate();
    cs_n = 1'b0; tick(4);
    up_dn = 1'b1; tick(4);
    for (int i = 0; i < 30; i++) pulse(1);
    check("R2 reach top", wiper_pos, 31);
    check_pos("R2 top");
    pulse(1);
    check_pos("R2 stay at top");
    up_dn = 1'b0; tick(4);
    for (int i = 0; i < 35; i++) pulse(1);
    check("R2 reach bottom", wiper_pos, 0);
    pulse(1);
    check_pos("R2 stay at bottom");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_up_down();
    t_store();
    t_desel_nostore(3);
    t_busy_ignore();
    t_saturate();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule